// File: doc/BRIEF.md
# Boot Memory Remap Address Router

This block connects one bus master to two memory targets, an on-chip block RAM and a serial-flash read window. Two fixed 2 MiB address windows exist, one based at 0x0000_0000 and one at 0x2800_0000. A single select bit decides which target answers in which window. With the bit clear, the block RAM sits at the low window and the flash at the high one. With it set, the two are exchanged, so the flash answers at address 0. A request is sent to the target mapped at the decoded window, with the address reduced to its offset inside that window. An address that falls in neither window gets an error response and reaches no target.

While reset is asserted, the select bit follows an external boot strap on every clock. The chosen mapping is therefore already in place when reset is released, and the very first fetch at address 0 (the vector table) goes to the chosen target. Software can later rewrite the bit through a one-register write port, and it can read the current value back on a read bus. A new value never applies while a transfer is outstanding. It is held until the router is idle, and new requests are stalled until it has applied.

The master side uses valid/ready handshakes in both directions. A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. The master must hold a request stable until it is accepted. Only one transfer is in flight at a time, and `req_ready` stays low from acceptance until the response has been taken. A response is held with stable `rsp_rdata` and `rsp_err` for as long as `rsp_ready` stays low. Targets receive a valid/ready request. Each target answers with a single-cycle `*_rsp_valid` pulse, which the router always accepts.

Top module: `boot_remap_router`

## Requirements
- R1: While `rst_n` is low the select bit takes the value of `boot_strap` on each clock. After release, `cfg_rd_data` equals {31 zeros, strap}, no response is pending, and a first request at address 0 goes to the flash if the strap was 1 and to the block RAM if it was 0.
- R2: With the select bit at 0, an address in [0x0000_0000, 0x0020_0000) goes only to the block RAM and an address in [0x2800_0000, 0x2820_0000) goes only to the flash. The target address is the request address minus the window base (21 bits).
- R3: With the select bit at 1, an address in the low window goes only to the flash and an address in the high window goes only to the block RAM, again as an offset from the window base.
- R4: A request outside both windows is accepted without reaching either target. It is answered with `rsp_err`=1 and `rsp_rdata`=0 in the cycle after acceptance.
- R5: A pulse on `cfg_wr_en` loads bit 0 of `cfg_wr_data` as the new select bit, and the new map applies to later requests. `cfg_rd_data` returns the select bit in bit 0, and its other bits read 0 whatever was written.
- R6: A select write that arrives while a transfer is outstanding leaves `cfg_rd_data` and the map unchanged until the response is taken. It then applies before any further request is accepted.
- R7: Only one transfer is outstanding at a time. `req_ready` is low while a response is pending and while the addressed target holds its ready low, and at most one target valid is high in any cycle. A response held by `rsp_ready`=0 keeps `rsp_valid`, `rsp_rdata` and `rsp_err` stable.
- R8: A target's read data returned on its `*_rsp_valid` pulse appears on `rsp_rdata` with `rsp_err`=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| boot_strap | input | 1 | Select value loaded during reset (0 RAM low, 1 flash low) |
| cfg_wr_en | input | 1 | Write strobe for the select register |
| cfg_wr_data | input | 32 | Write data; bit 0 is the new select value |
| cfg_rd_data | output | 32 | Select register read value |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Master request accepted |
| req_addr | input | 32 | Master request address |
| req_write | input | 1 | Request is a write |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Response is a decode error |
| ram_req_valid | output | 1 | Block RAM request valid |
| ram_req_ready | input | 1 | Block RAM ready |
| ram_req_addr | output | 21 | Block RAM offset |
| ram_req_write | output | 1 | Block RAM write |
| ram_req_wdata | output | 32 | Block RAM write data |
| ram_rsp_valid | input | 1 | Block RAM response pulse |
| ram_rsp_rdata | input | 32 | Block RAM read data |
| flash_req_valid | output | 1 | Flash request valid |
| flash_req_ready | input | 1 | Flash ready |
| flash_req_addr | output | 21 | Flash offset |
| flash_req_write | output | 1 | Flash write |
| flash_req_wdata | output | 32 | Flash write data |
| flash_rsp_valid | input | 1 | Flash response pulse |
| flash_rsp_rdata | input | 32 | Flash read data |

## Verification
The hardest case to reach is a select write that lands while a transfer is waiting on a slow target. The map must stay frozen through that wait and through a held response, and then change before the next request. The bench makes the RAM model's latency six cycles and issues the write in the middle of the wait. It holds `rsp_ready` low for a while, watches `cfg_rd_data` stay put, and then checks that the next fetch at address 0 reaches the flash. The strap-selected boot is reached by a second reset with the strap high and an immediate fetch at address 0.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int NUM_TGT = 2;
  localparam int TGT_RAM = 0;
  localparam int TGT_FLASH = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } xact_state_e;
endpackage

// File: rtl/remap_cfg.sv
module remap_cfg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              idle_i,
  output logic              pend_o,
  output logic              sel_o
);
  logic pend_q;
  logic pval_q;
  logic sel_q;
  logic apply;
  logic wr_unused;

  assign wr_unused = ^wr_data_i[DATA_W-1:1];
  assign apply = idle_i && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else if (wr_en_i) begin
      pend_q <= 1'b1;
      pval_q <= wr_data_i[0];
    end else if (apply) begin
      pend_q <= 1'b0;
    end
  end

  // strap is sampled every clock while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= strap_i;
    else if (apply) sel_q <= pval_q;
  end

  assign pend_o = pend_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/remap_decode.sv
module remap_decode #(
  parameter int ADDR_W = 32,
  parameter int WIN_LOG2 = 21,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 32'h2800_0000
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                sel_i,
  output logic                hit_o,
  output logic                tgt_o,
  output logic [WIN_LOG2-1:0] off_o
);
  localparam int NWIN = 2;

  logic [NWIN-1:0]               win_hit;
  logic [NWIN-1:0][WIN_LOG2-1:0] win_off;
  logic [NWIN-1:0]               diff_unused;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = (w == 0) ? WIN0_BASE : WIN1_BASE;
    logic [ADDR_W-1:0] diff;
    assign win_hit[w] = (addr_i[ADDR_W-1:WIN_LOG2] == BASE[ADDR_W-1:WIN_LOG2]);
    assign diff = addr_i - BASE;
    assign win_off[w] = diff[WIN_LOG2-1:0];
    assign diff_unused[w] = ^diff[ADDR_W-1:WIN_LOG2];
  end

  assign hit_o = |win_hit;
  // target index = window index XOR select
  assign tgt_o = win_hit[1] ^ sel_i;
  assign off_o = win_hit[1] ? win_off[1] : win_off[0];
endmodule

// File: rtl/remap_xact.sv
module remap_xact
  import remap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hold_i,
  input  logic                           req_valid_i,
  input  logic                           hit_i,
  input  logic                           tgt_i,
  output logic                           req_ready_o,
  output logic [NUM_TGT-1:0]             tgt_valid_o,
  input  logic [NUM_TGT-1:0]             tgt_ready_i,
  input  logic [NUM_TGT-1:0]             tgt_rsp_valid_i,
  input  logic [NUM_TGT-1:0][DATA_W-1:0] tgt_rsp_rdata_i,
  output logic                           rsp_valid_o,
  input  logic                           rsp_ready_i,
  output logic [DATA_W-1:0]              rsp_rdata_o,
  output logic                           rsp_err_o,
  output logic                           idle_o
);
  xact_state_e       state_q;
  logic              cur_q;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic              open;

  assign open = (state_q == ST_IDLE) && !hold_i;
  assign req_ready_o = open && (!hit_i || tgt_ready_i[tgt_i]);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign tgt_valid_o[t] = open && req_valid_i && hit_i && (tgt_i == t[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i && req_ready_o) begin
            if (!hit_i) begin
              state_q <= ST_RESP;
              rdata_q <= '0;
              err_q   <= 1'b1;
            end else begin
              state_q <= ST_WAIT;
              cur_q   <= tgt_i;
            end
          end
        end
        ST_WAIT: begin
          if (tgt_rsp_valid_i[cur_q]) begin
            state_q <= ST_RESP;
            rdata_q <= tgt_rsp_rdata_i[cur_q];
            err_q   <= 1'b0;
          end
        end
        ST_RESP: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_rdata_o = rdata_q;
  assign rsp_err_o = err_q;
  assign idle_o = (state_q == ST_IDLE);
endmodule

// File: rtl/boot_remap_router.sv
module boot_remap_router
  import remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LOG2 = 21,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 32'h2800_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_strap,
  input  logic                cfg_wr_en,
  input  logic [DATA_W-1:0]   cfg_wr_data,
  output logic [DATA_W-1:0]   cfg_rd_data,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                ram_req_valid,
  input  logic                ram_req_ready,
  output logic [WIN_LOG2-1:0] ram_req_addr,
  output logic                ram_req_write,
  output logic [DATA_W-1:0]   ram_req_wdata,
  input  logic                ram_rsp_valid,
  input  logic [DATA_W-1:0]   ram_rsp_rdata,
  output logic                flash_req_valid,
  input  logic                flash_req_ready,
  output logic [WIN_LOG2-1:0] flash_req_addr,
  output logic                flash_req_write,
  output logic [DATA_W-1:0]   flash_req_wdata,
  input  logic                flash_rsp_valid,
  input  logic [DATA_W-1:0]   flash_rsp_rdata
);
  logic                           sel;
  logic                           pend;
  logic                           idle;
  logic                           hit;
  logic                           tgt;
  logic [WIN_LOG2-1:0]            off;
  logic [NUM_TGT-1:0]             tvalid;
  logic [NUM_TGT-1:0]             tready;
  logic [NUM_TGT-1:0]             trsp_valid;
  logic [NUM_TGT-1:0][DATA_W-1:0] trsp_rdata;

  remap_cfg #(.DATA_W(DATA_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .strap_i(boot_strap),
    .wr_en_i(cfg_wr_en), .wr_data_i(cfg_wr_data),
    .idle_i(idle), .pend_o(pend), .sel_o(sel)
  );

  remap_decode #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2),
    .WIN0_BASE(WIN0_BASE), .WIN1_BASE(WIN1_BASE)
  ) i_dec (
    .addr_i(req_addr), .sel_i(sel), .hit_o(hit), .tgt_o(tgt), .off_o(off)
  );

  remap_xact #(.DATA_W(DATA_W)) i_xact (
    .clk(clk), .rst_n(rst_n), .hold_i(pend),
    .req_valid_i(req_valid), .hit_i(hit), .tgt_i(tgt),
    .req_ready_o(req_ready), .tgt_valid_o(tvalid), .tgt_ready_i(tready),
    .tgt_rsp_valid_i(trsp_valid), .tgt_rsp_rdata_i(trsp_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err), .idle_o(idle)
  );

  assign cfg_rd_data = {{(DATA_W-1){1'b0}}, sel};

  assign tready     = {flash_req_ready, ram_req_ready};
  assign trsp_valid = {flash_rsp_valid, ram_rsp_valid};
  assign trsp_rdata[TGT_RAM]   = ram_rsp_rdata;
  assign trsp_rdata[TGT_FLASH] = flash_rsp_rdata;

  assign ram_req_valid   = tvalid[TGT_RAM];
  assign ram_req_addr    = off;
  assign ram_req_write   = req_write;
  assign ram_req_wdata   = req_wdata;
  assign flash_req_valid = tvalid[TGT_FLASH];
  assign flash_req_addr  = off;
  assign flash_req_write = req_write;
  assign flash_req_wdata = req_wdata;
endmodule

// File: rtl/remap_chk.sv
module remap_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WIN_LOG2 = 21,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 32'h0000_0000,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 32'h2800_0000
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DATA_W-1:0]   cfg_rd_data,
  input logic                req_valid,
  input logic                req_ready,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                rsp_valid,
  input logic                rsp_ready,
  input logic [DATA_W-1:0]   rsp_rdata,
  input logic                rsp_err,
  input logic                ram_req_valid,
  input logic [WIN_LOG2-1:0] ram_req_addr,
  input logic                flash_req_valid,
  input logic [WIN_LOG2-1:0] flash_req_addr
);
  logic in_lo;
  logic in_hi;
  assign in_lo = (req_addr[ADDR_W-1:WIN_LOG2] == WIN0_BASE[ADDR_W-1:WIN_LOG2]);
  assign in_hi = (req_addr[ADDR_W-1:WIN_LOG2] == WIN1_BASE[ADDR_W-1:WIN_LOG2]);

  // R2
  ram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_valid |-> (cfg_rd_data[0] ? in_hi : in_lo));
  // R3
  flash_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req_valid |-> (cfg_rd_data[0] ? in_lo : in_hi));
  // R2
  ram_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req_valid |-> (ram_req_addr == req_addr[WIN_LOG2-1:0]));
  // R3
  flash_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_req_valid |-> (flash_req_addr == req_addr[WIN_LOG2-1:0]));
  // R4
  miss_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !in_lo && !in_hi) |=> (rsp_valid && rsp_err && rsp_rdata == '0));
  // R7
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_req_valid, flash_req_valid}));
  // R7
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R7
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));
  // R6
  sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> $stable(cfg_rd_data));
endmodule

bind boot_remap_router remap_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2),
  .WIN0_BASE(WIN0_BASE), .WIN1_BASE(WIN1_BASE)
) i_remap_chk (.*);

// File: tb/test_boot_remap_router.sv
`timescale 1ns/1ps
module test_boot_remap_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_strap = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic [31:0] cfg_rd_data;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        ram_req_valid, flash_req_valid;
  logic        ram_req_ready, flash_req_ready;
  logic [20:0] ram_req_addr, flash_req_addr;
  logic        ram_req_write, flash_req_write;
  logic [31:0] ram_req_wdata, flash_req_wdata;
  logic        ram_rsp_valid, flash_rsp_valid;
  logic [31:0] ram_rsp_rdata, flash_rsp_rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  boot_remap_router i_boot_remap_router (.*);

  // target models: response pulse lat cycles after acceptance
  logic ram_rdy = 1'b1, flash_rdy = 1'b1;
  int   ram_lat = 1, flash_lat = 1;
  int   ram_hits = 0, flash_hits = 0;
  logic ram_busy = 0, flash_busy = 0;
  int   ram_cnt = 0, flash_cnt = 0;
  logic [31:0] ram_dq = '0, flash_dq = '0;

  assign ram_req_ready = ram_rdy;
  assign flash_req_ready = flash_rdy;
  assign ram_rsp_valid = ram_busy && (ram_cnt == 0);
  assign flash_rsp_valid = flash_busy && (flash_cnt == 0);
  assign ram_rsp_rdata = ram_dq;
  assign flash_rsp_rdata = flash_dq;

  always @(posedge clk) begin
    if (ram_req_valid && ram_req_ready) begin
      ram_busy <= 1; ram_cnt <= ram_lat; ram_dq <= 32'hA000_0000 | {11'd0, ram_req_addr};
      ram_hits <= ram_hits + 1;
    end else if (ram_busy) begin
      if (ram_cnt == 0) ram_busy <= 0; else ram_cnt <= ram_cnt - 1;
    end
    if (flash_req_valid && flash_req_ready) begin
      flash_busy <= 1; flash_cnt <= flash_lat; flash_dq <= 32'hF000_0000 | {11'd0, flash_req_addr};
      flash_hits <= flash_hits + 1;
    end else if (flash_busy) begin
      if (flash_cnt == 0) flash_busy <= 0; else flash_cnt <= flash_cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 0; boot_strap = strap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_data = d;
    @(posedge clk); #1;
    cfg_wr_en = 0;
    repeat (3) @(negedge clk);
  endtask

  // exp_t: 0 ram, 1 flash, 2 decode error
  task automatic do_xact(input logic [31:0] a, input int exp_t, input string tag);
    logic [20:0] off;
    logic [31:0] exp_d;
    off = (a >= 32'h2800_0000) ? 21'(a - 32'h2800_0000) : a[20:0];
    exp_d = (exp_t == 0) ? (32'hA000_0000 | {11'd0, off}) :
            (exp_t == 1) ? (32'hF000_0000 | {11'd0, off}) : 32'h0;
    @(negedge clk);
    req_valid = 1; req_addr = a;
    #1;
    chk(ram_req_valid == (exp_t == 0), {tag, " ram_valid"}, {31'd0, ram_req_valid}, {31'd0, exp_t == 0});
    chk(flash_req_valid == (exp_t == 1), {tag, " flash_valid"}, {31'd0, flash_req_valid}, {31'd0, exp_t == 1});
    if (exp_t == 0) chk(ram_req_addr == off, {tag, " ram_off"}, {11'd0, ram_req_addr}, {11'd0, off});
    if (exp_t == 1) chk(flash_req_addr == off, {tag, " flash_off"}, {11'd0, flash_req_addr}, {11'd0, off});
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_err == (exp_t == 2), {tag, " err"}, {31'd0, rsp_err}, {31'd0, exp_t == 2});
    chk(rsp_rdata == exp_d, {tag, " rdata"}, rsp_rdata, exp_d);
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
  endtask

  task automatic t_reset_default;
    do_reset(1'b0);
    chk(cfg_rd_data == 32'h0, "R1 reset sel", cfg_rd_data, 32'h0);
    chk(!rsp_valid, "R1 no rsp", {31'd0, rsp_valid}, 32'h0);
    do_xact(32'h0000_0000, 0, "R1 boot fetch ram");
  endtask

  task automatic t_default_map;
    do_xact(32'h0000_1234, 0, "R2 low ram");
    do_xact(32'h001F_FFFC, 0, "R2 low edge ram");
    do_xact(32'h2800_0010, 1, "R2 high flash");
    do_xact(32'h281F_FFFC, 1, "R2 high edge flash");
  endtask

  task automatic t_miss;
    int rh, fh;
    rh = ram_hits; fh = flash_hits;
    do_xact(32'h0020_0000, 2, "R4 above low");
    do_xact(32'h27FF_FFFC, 2, "R4 below high");
    do_xact(32'h2820_0000, 2, "R4 above high");
    chk(ram_hits == rh && flash_hits == fh, "R4 no target hit", ram_hits + flash_hits, rh + fh);
  endtask

  task automatic t_cfg;
    cfg_write(32'h0000_0001);
    chk(cfg_rd_data == 32'h1, "R5 read sel 1", cfg_rd_data, 32'h1);
    do_xact(32'h0000_0040, 1, "R3 low flash");
    do_xact(32'h2800_0044, 0, "R3 high ram");
    do_xact(32'h2900_0000, 2, "R4 miss alt map");
    cfg_write(32'hFFFF_FFFE);
    chk(cfg_rd_data == 32'h0, "R5 upper ignored", cfg_rd_data, 32'h0);
    do_xact(32'h0000_0008, 0, "R5 back to ram");
    cfg_write(32'h0000_0003);
    chk(cfg_rd_data == 32'h1, "R5 read only bit0", cfg_rd_data, 32'h1);
    cfg_write(32'h0);
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    ram_rdy = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_0100;
    repeat (3) begin
      @(negedge clk);
      chk(!req_ready, "R7 tgt not ready", {31'd0, req_ready}, 32'h0);
    end
    ram_rdy = 1;
    #1;
    chk(req_ready, "R7 ready follows tgt", {31'd0, req_ready}, 32'h1);
    @(posedge clk); #1;
    req_addr = 32'h2800_0200;   // second request kept valid
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    held = rsp_rdata;
    chk(held == 32'hA000_0100, "R8 rdata", held, 32'hA000_0100);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == held && !rsp_err, "R7 rsp held", rsp_rdata, held);
      chk(!req_ready && !flash_req_valid, "R7 second blocked", {31'd0, flash_req_valid}, 32'h0);
    end
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 32'hF000_0200, "R8 second rdata", rsp_rdata, 32'hF000_0200);
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
  endtask

  task automatic t_held_write;
    ram_lat = 6;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_0300;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_data = 32'h1;
    @(posedge clk); #1;
    cfg_wr_en = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      chk(cfg_rd_data == 32'h0, "R6 frozen in wait", cfg_rd_data, 32'h0);
    end
    chk(rsp_rdata == 32'hA000_0300, "R6 old map data", rsp_rdata, 32'hA000_0300);
    repeat (2) begin
      @(negedge clk);
      chk(cfg_rd_data == 32'h0, "R6 frozen in resp", cfg_rd_data, 32'h0);
    end
    rsp_ready = 1;
    @(posedge clk); #1;
    rsp_ready = 0;
    repeat (2) @(negedge clk);
    chk(cfg_rd_data == 32'h1, "R6 applied after", cfg_rd_data, 32'h1);
    ram_lat = 1;
    do_xact(32'h0000_0000, 1, "R6 next to flash");
  endtask

  task automatic t_strap_boot;
    do_reset(1'b1);
    chk(cfg_rd_data == 32'h1, "R1 strap sel", cfg_rd_data, 32'h1);
    do_xact(32'h0000_0000, 1, "R1 boot fetch flash");
    do_xact(32'h2800_0000, 0, "R1 ram high");
  endtask

  initial begin
    t_reset_default();
    t_default_map();
    t_miss();
    t_cfg();
    t_backpressure();
    t_held_write();
    t_strap_boot();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule